// File: doc/BRIEF.md
# Dual-Mode Interrupt Priority Router

This block collects six level-sensitive interrupt requests and turns them into one CPU interrupt priority level with an autovector number. The six sources are two peripheral interface controllers, ethernet, serial, sound and a non-maskable source. A pending register holds a level image of the routed requests. The highest pending bit sets the level driven to the CPU.

A mode pin picks one of two routing tables at run time. In classic mode, two sources do not reach the CPU levels. Ethernet is forwarded unchanged to an expansion-slot interrupt line. Sound is forwarded inverted to a line that signals a downstream controller on a falling edge. A built-in stretcher turns a single-cycle NMI request into a non-maskable request that stays asserted for a programmable number of clock cycles.

The router updates pending bits only when a source changes. A mode switch therefore leaves bits that are already pending where they are. Every output changes on the clock edge that follows the input change that causes it.

Top module: `irq_prio_router`

## Requirements
- R1: The mode is held in a register that reset forces to 0 (alternate mode) and that samples `mode_i` on every clock edge. A source change seen at a clock edge is routed with the mode sampled at the previous edge. A source and the mode changing in the same cycle therefore uses the old mode.
- R2: In alternate mode (mode 0), sources map to pending bits as follows: controller A to bit 5, controller B to bit 1, ethernet to bit 2, serial to bit 3, sound to bit 4, and the non-maskable line to bit 6.
- R3: In classic mode (mode 1), sources map as follows: controller A to bit 0, controller B to bit 1, serial to bit 3, and the non-maskable line to bit 6. Ethernet and sound leave the pending register untouched.
- R4: In classic mode, a change on the ethernet request is copied unchanged to `slot_irq_o` at the next edge.
- R5: In classic mode, a change on the sound request drives its inverse onto `snd_edge_o` at the next edge. Both side lines hold their value in alternate mode. After reset, `slot_irq_o` is 0 and `snd_edge_o` is 1.
- R6: A routed source sets its pending bit when it rises and clears the bit when it falls. Bits change only on a source change, so a mode switch does not rewrite bits that are already pending.
- R7: With highest set pending bit k, `cpu_level_o` is k+1 and `cpu_vector_o` is k+25.
- R8: With no pending bit set, `cpu_level_o` and `cpu_vector_o` are both 0.
- R9: Reset clears every pending bit and cancels any NMI hold in progress.
- R10: A one-cycle `nmi_pulse_i` makes the non-maskable line high for exactly HOLD_CYCLES cycles, starting at the next edge. A new pulse during a hold restarts the full count.
- R11: The non-maskable line is the OR of `nmi_irq_i` and the stretcher hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Routing mode: 0 alternate, 1 classic |
| ctl_a_irq_i | input | 1 | Interface controller A request |
| ctl_b_irq_i | input | 1 | Interface controller B request |
| eth_irq_i | input | 1 | Ethernet request |
| ser_irq_i | input | 1 | Serial request |
| snd_irq_i | input | 1 | Sound request |
| nmi_irq_i | input | 1 | Non-maskable level request |
| nmi_pulse_i | input | 1 | One-cycle trigger for the NMI stretcher |
| cpu_level_o | output | 3 | CPU interrupt priority level |
| cpu_vector_o | output | 8 | Autovector number |
| slot_irq_o | output | 1 | Ethernet forwarded to the expansion-slot line (classic mode) |
| snd_edge_o | output | 1 | Inverted sound request for falling-edge signalling (classic mode) |

## Verification
The hardest state to reach is a pending bit that the current mode can no longer clear. The bench raises controller A in alternate mode so that bit 5 is set. It then switches to classic mode and drops controller A. That change clears bit 0 and leaves bit 5 set, so the level stays at 6. The bench also changes the mode and a source in the same cycle, and it fires a second NMI pulse partway through a hold. A behavioural model follows every clock and predicts the level, vector and side lines for each of these cases.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int NUM_SRC  = 6;
    localparam int PEND_W   = 8;
    localparam int IDX_W    = $clog2(PEND_W);
    localparam int LVL_W    = 3;
    localparam int VEC_W    = 8;
    localparam logic [VEC_W-1:0] VEC_BASE = 8'd25;

    typedef enum logic [2:0] {
        SRC_CTL_A = 3'd0,
        SRC_CTL_B = 3'd1,
        SRC_ETH   = 3'd2,
        SRC_SER   = 3'd3,
        SRC_SND   = 3'd4,
        SRC_NMI   = 3'd5
    } src_e;

    typedef struct packed {
        logic             routed;
        logic [IDX_W-1:0] bit_idx;
    } route_t;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vector;
    } cpu_req_t;

    // Pending-bit target of a source under the given mode.
    function automatic route_t route_of(src_e s, logic classic);
        route_t r;
        r.routed  = 1'b1;
        r.bit_idx = '0;
        case (s)
            SRC_CTL_A: r.bit_idx = classic ? IDX_W'(0) : IDX_W'(5);
            SRC_CTL_B: r.bit_idx = IDX_W'(1);
            SRC_ETH: begin
                r.routed  = ~classic;
                r.bit_idx = IDX_W'(2);
            end
            SRC_SER:   r.bit_idx = IDX_W'(3);
            SRC_SND: begin
                r.routed  = ~classic;
                r.bit_idx = IDX_W'(4);
            end
            SRC_NMI:   r.bit_idx = IDX_W'(6);
            default:   r.routed  = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_nmi_stretch.sv
module irq_nmi_stretch #(
    parameter int HOLD_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (pulse_i) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign active_o = (cnt_q != '0);

endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
    import irq_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               classic_i,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [PEND_W-1:0]  pend_o,
    output logic               slot_o,
    output logic               snd_edge_o
);
    logic [NUM_SRC-1:0] prev_q;
    logic [PEND_W-1:0]  pend_q;
    logic               slot_q;
    logic               snd_q;
    route_t             rt [NUM_SRC];
    logic [NUM_SRC-1:0] chg;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_route
        assign rt[g]  = route_of(src_e'(3'(g)), classic_i);
        assign chg[g] = src_i[g] ^ prev_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
            slot_q <= 1'b0;
            snd_q  <= 1'b1;
        end else begin
            prev_q <= src_i;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (chg[s] && rt[s].routed) begin
                    pend_q[rt[s].bit_idx] <= src_i[s];
                end
            end
            if (chg[SRC_ETH] && !rt[SRC_ETH].routed) begin
                slot_q <= src_i[SRC_ETH];
            end
            if (chg[SRC_SND] && !rt[SRC_SND].routed) begin
                snd_q <= ~src_i[SRC_SND];
            end
        end
    end

    assign pend_o     = pend_q;
    assign slot_o     = slot_q;
    assign snd_edge_o = snd_q;

endmodule

// File: rtl/irq_prio_encode.sv
module irq_prio_encode
    import irq_route_pkg::*;
(
    input  logic [PEND_W-1:0] pend_i,
    output cpu_req_t          req_o
);
    logic             found;
    logic [IDX_W-1:0] top;

    always_comb begin
        found = 1'b0;
        top   = '0;
        for (int i = 0; i < PEND_W; i++) begin
            if (pend_i[i]) begin
                found = 1'b1;
                top   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (found) begin
            req_o.level  = LVL_W'({1'b0, top} + (IDX_W+1)'(1));
            req_o.vector = VEC_W'(top) + VEC_BASE;
        end else begin
            req_o.level  = '0;
            req_o.vector = '0;
        end
    end

endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
    import irq_route_pkg::*;
#(
    parameter int HOLD_CYCLES = 5_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_i,
    input  logic       ctl_a_irq_i,
    input  logic       ctl_b_irq_i,
    input  logic       eth_irq_i,
    input  logic       ser_irq_i,
    input  logic       snd_irq_i,
    input  logic       nmi_irq_i,
    input  logic       nmi_pulse_i,
    output logic [2:0] cpu_level_o,
    output logic [7:0] cpu_vector_o,
    output logic       slot_irq_o,
    output logic       snd_edge_o
);
    logic               mode_q;
    logic               hold_active;
    logic               nmi_line;
    logic [NUM_SRC-1:0] src;
    logic [PEND_W-1:0]  pend;
    cpu_req_t           req;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= mode_i;
    end

    irq_nmi_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
        .clk      (clk),
        .rst      (rst),
        .pulse_i  (nmi_pulse_i),
        .active_o (hold_active)
    );

    assign nmi_line = nmi_irq_i | hold_active;

    always_comb begin
        src            = '0;
        src[SRC_CTL_A] = ctl_a_irq_i;
        src[SRC_CTL_B] = ctl_b_irq_i;
        src[SRC_ETH]   = eth_irq_i;
        src[SRC_SER]   = ser_irq_i;
        src[SRC_SND]   = snd_irq_i;
        src[SRC_NMI]   = nmi_line;
    end

    irq_src_router u_router (
        .clk        (clk),
        .rst        (rst),
        .classic_i  (mode_q),
        .src_i      (src),
        .pend_o     (pend),
        .slot_o     (slot_irq_o),
        .snd_edge_o (snd_edge_o)
    );

    irq_prio_encode u_enc (
        .pend_i (pend),
        .req_o  (req)
    );

    assign cpu_level_o  = req.level;
    assign cpu_vector_o = req.vector;

endmodule

// File: rtl/irq_prio_router_chk.sv
module irq_prio_router_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_q,
    input logic       hold_active,
    input logic       nmi_pulse_i,
    input logic [7:0] pend,
    input logic [2:0] cpu_level_o,
    input logic [7:0] cpu_vector_o,
    input logic       slot_irq_o,
    input logic       snd_edge_o
);
    // R7: the vector follows the level with a fixed offset
    a_r7_vector_tracks_level: assert property (@(posedge clk) disable iff (rst)
        (cpu_level_o != 3'd0) |-> (cpu_vector_o == {5'd0, cpu_level_o} + 8'd24));

    // R7: the level points at the highest pending bit
    a_r7_top_bit: assert property (@(posedge clk) disable iff (rst)
        (cpu_level_o != 3'd0) |-> (pend[3'(cpu_level_o - 3'd1)] && ((pend >> cpu_level_o) == 8'd0)));

    // R8: no pending bit means level and vector are zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (pend == 8'd0) |-> (cpu_level_o == 3'd0 && cpu_vector_o == 8'd0));

    // R3: classic mode never touches the ethernet and sound bits
    a_r3_classic_spares_bits: assert property (@(posedge clk) disable iff (rst)
        mode_q |=> ($stable(pend[2]) && $stable(pend[5:4])));

    // R5: side lines hold in alternate mode
    a_r5_side_hold_low: assert property (@(posedge clk) disable iff (rst)
        !mode_q |=> ($stable(slot_irq_o) && $stable(snd_edge_o)));

    // R10: a pulse starts a hold at the next edge
    a_r10_pulse_holds: assert property (@(posedge clk) disable iff (rst)
        nmi_pulse_i |=> hold_active);

    // R9: reset clears the outputs and cancels the hold
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (cpu_level_o == 3'd0 && !hold_active));

endmodule

bind irq_prio_router irq_prio_router_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_q       (mode_q),
    .hold_active  (hold_active),
    .nmi_pulse_i  (nmi_pulse_i),
    .pend         (pend),
    .cpu_level_o  (cpu_level_o),
    .cpu_vector_o (cpu_vector_o),
    .slot_irq_o   (slot_irq_o),
    .snd_edge_o   (snd_edge_o)
);

// File: tb/test_irq_prio_router.sv
`timescale 1ns/1ps
module test_irq_prio_router;
    localparam int HOLD = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b0;
    logic ctl_a = 1'b0, ctl_b = 1'b0, eth = 1'b0, ser = 1'b0, snd = 1'b0;
    logic nmi = 1'b0, pulse = 1'b0;
    logic [2:0] level;
    logic [7:0] vector;
    logic slot, sedge;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    bit m_mode;
    bit m_prev [6];
    bit m_pend [8];
    bit m_slot;
    bit m_snd;
    int m_cnt;

    always #10 clk = ~clk;

    irq_prio_router #(.HOLD_CYCLES(HOLD)) i_irq_prio_router (
        .clk(clk), .rst(rst), .mode_i(mode),
        .ctl_a_irq_i(ctl_a), .ctl_b_irq_i(ctl_b), .eth_irq_i(eth),
        .ser_irq_i(ser), .snd_irq_i(snd), .nmi_irq_i(nmi), .nmi_pulse_i(pulse),
        .cpu_level_o(level), .cpu_vector_o(vector),
        .slot_irq_o(slot), .snd_edge_o(sedge)
    );

    // R2/R3 mapping: -1 means diverted to a side line
    function automatic int map_bit(int s, bit classic);
        case (s)
            0: return classic ? 0 : 5;
            1: return 1;
            2: return classic ? -1 : 2;
            3: return 3;
            4: return classic ? -1 : 4;
            default: return 6;
        endcase
    endfunction

    task automatic model_edge();
        bit cur [6];
        if (rst) begin
            m_mode = 0; m_slot = 0; m_snd = 1; m_cnt = 0;
            foreach (m_prev[i]) m_prev[i] = 0;
            foreach (m_pend[i]) m_pend[i] = 0;
            return;
        end
        cur[0] = ctl_a; cur[1] = ctl_b; cur[2] = eth;
        cur[3] = ser;   cur[4] = snd;   cur[5] = nmi | (m_cnt > 0);
        for (int s = 0; s < 6; s++) begin
            if (cur[s] != m_prev[s]) begin
                int b = map_bit(s, m_mode);
                if (b >= 0) m_pend[b] = cur[s];
                else if (s == 2) m_slot = cur[s];
                else m_snd = !cur[s];
            end
            m_prev[s] = cur[s];
        end
        if (pulse) m_cnt = HOLD;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        m_mode = mode;
    endtask

    task automatic compare(string tag);
        int top = -1;
        int exp_lvl, exp_vec;
        for (int i = 0; i < 8; i++) if (m_pend[i]) top = i;
        exp_lvl = (top < 0) ? 0 : top + 1;
        exp_vec = (top < 0) ? 0 : top + 25;
        checks++;
        if (int'(level) != exp_lvl || int'(vector) != exp_vec ||
            slot != m_slot || sedge != m_snd) begin
            errors++;
            $display("FAIL %s level=%0d vec=%0d slot=%0b snd=%0b expected level=%0d vec=%0d slot=%0b snd=%0b",
                     tag, level, vector, slot, sedge, exp_lvl, exp_vec, m_slot, m_snd);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic steps(int n, string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        steps(3, "R9 reset state");
        rst = 0;
        step("R8 idle");

        // R2: alternate mode, each routed source alone
        ctl_a = 1; step("R2 ctl_a bit5"); ctl_a = 0; step("R2 ctl_a clear R6");
        ctl_b = 1; step("R2 ctl_b bit1"); ctl_b = 0; step("R2 ctl_b clear");
        eth = 1;   step("R2 eth bit2");   eth = 0;   step("R2 eth clear");
        ser = 1;   step("R2 ser bit3");   ser = 0;   step("R2 ser clear");
        snd = 1;   step("R2 snd bit4");   snd = 0;   step("R2 snd clear");
        nmi = 1;   step("R11 nmi level bit6"); nmi = 0; step("R11 nmi clear");

        // R7: priority across several sources
        ctl_b = 1; ser = 1; step("R7 two pending");
        snd = 1; step("R7 higher wins");
        snd = 0; ser = 0; step("R7 fall back to bit1");
        ctl_b = 0; step("R8 back to idle");

        // R1: mode and source change together use the old mode
        mode = 1; ctl_a = 1; step("R1 same-cycle mode change");
        // R6: classic drop of ctl_a clears bit0, bit5 stays pending
        ctl_a = 0; step("R6 stale bit kept");
        mode = 0; step("R1 mode back");
        ctl_a = 1; step("R6 alt re-raise"); ctl_a = 0; step("R6 alt clears bit5");

        // R3, R4, R5 in classic mode
        mode = 1; step("R3 enter classic");
        ctl_a = 1; step("R3 ctl_a bit0"); ctl_a = 0; step("R3 clear");
        ser = 1; step("R3 ser bit3"); ser = 0; step("R3 ser clear");
        eth = 1; step("R4 eth to slot"); eth = 0; step("R4 slot follows");
        snd = 1; step("R5 snd inverted"); snd = 0; step("R5 snd back");
        eth = 1; snd = 1; step("R4 R5 side lines set");
        mode = 0; step("R5 leave classic");
        eth = 0; snd = 0; step("R5 side lines hold in alternate");
        step("R5 hold");
        eth = 1; snd = 1; step("R2 alt eth snd bits"); eth = 0; snd = 0; step("R2 alt clear");

        // R10: stretcher
        pulse = 1; step("R10 pulse"); pulse = 0;
        steps(HOLD + 3, "R10 hold window");
        pulse = 1; step("R10 pulse again"); pulse = 0;
        steps(5, "R10 mid hold");
        pulse = 1; step("R10 restart"); pulse = 0;
        steps(HOLD + 3, "R10 restarted window");
        mode = 1; pulse = 1; step("R10 classic pulse"); pulse = 0;
        steps(HOLD + 3, "R10 classic window");
        mode = 0;

        // R9: reset during a hold with sources pending
        ctl_b = 1; pulse = 1; step("R9 setup"); pulse = 0;
        steps(3, "R9 hold active");
        rst = 1; ctl_b = 0; step("R9 reset in hold");
        rst = 0; steps(HOLD + 2, "R9 hold cancelled");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule